// File: doc/BRIEF.md
# Programmable Carrier Generator with Two-Set Frequency Shift

The block produces a rectangular carrier for an infrared-style transmitter. The carrier's high time and low time each last a programmable number of ticks. A tick is the bus clock divided by 1, 2, 4 or 8, chosen by a two-bit divide select. The period is the sum of the two counts, and the duty cycle is the high count over that sum. The shortest period is one tick high and one tick low. A five-tick period, for example, allows only 20, 40, 60 or 80 percent duty. Longer periods give finer steps.

Two count pairs are held: a primary pair and an alternate pair. A set-select input picks the active pair, so a modulator can shift between two carrier frequencies without processor help. A new selection, or new count values, is taken only when a low phase ends and the next high phase begins, so no period is cut short. The generator runs only while the enable is set and the constant-high mode is clear. With the constant-high mode set, the output is held high. With the block disabled, the output is low and the counters restart. A zero count is used as one tick and sets a sticky error flag.

Top module: `carrier_gen`

## Requirements
- R1: After reset, with enable and hold_high low, carrier_out, period_end and zero_err are all 0.
- R2: With divide select 0, a period gives carrier_out high for the active high count of clock cycles, then low for the active low count of clock cycles. A period starts with its high phase.
- R3: Divide select value s (0..3) makes one tick last 2^s clock cycles, so each phase lasts count x 2^s cycles. After enable, the first tick ends 2^s cycles later.
- R4: period_end is 1 for exactly one clock cycle per period: the last cycle of the low phase. It is 0 at all other times.
- R5: With high and low counts both 1 and divide select 0, carrier_out toggles every cycle, and period_end is high every second cycle.
- R6: set_sel = 0 selects the primary pair (pri_high, pri_low). set_sel = 1 selects the alternate pair (alt_high, alt_low).
- R7: A change of set_sel or of the count inputs while running takes effect only from the next period. The period in progress completes with its old counts.
- R8: A count of 0 in the selected pair is used as a length of one tick. It sets zero_err, which stays 1 until reset.
- R9: While enable is 0 and hold_high is 0, carrier_out and period_end are 0. A later enable starts a fresh high phase with a fresh prescaler.
- R10: While hold_high is 1, carrier_out is 1 and period_end is 0, whatever the enable. Clearing hold_high with enable set starts a fresh high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| hold_high | input | 1 | Constant-high mode: carrier held at 1, counting stopped |
| div_sel | input | 2 | Tick = clock divided by 2^div_sel |
| pri_high | input | 8 | Primary high count in ticks |
| pri_low | input | 8 | Primary low count in ticks |
| alt_high | input | 8 | Alternate high count in ticks |
| alt_low | input | 8 | Alternate low count in ticks |
| set_sel | input | 1 | 0 primary pair, 1 alternate pair |
| carrier_out | output | 1 | Carrier |
| period_end | output | 1 | One-cycle strobe in the last cycle of each period |
| zero_err | output | 1 | Sticky flag: a zero count was loaded |

## Verification
The assertions assume that div_sel does not change while the generator runs. They also assume that rst_n is released away from the clock edge. The stimulus changes div_sel only while the block is idle, and changes every input one time unit after a rising edge. A mid-period change is limited to set_sel and the count inputs, which the block must defer. Zero counts are applied only in the test that checks the substitution and the sticky flag.

// File: rtl/carrier_pkg.sv
package carrier_pkg;
  parameter int unsigned CG_CNT_W = 8;
  parameter int unsigned CG_SEL_W = 2;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;
endpackage

// File: rtl/cg_prescaler.sv
module cg_prescaler
  import carrier_pkg::*;
#(
  parameter int unsigned SEL_W = CG_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, limit;

  always_comb begin
    for (int i = 0; i < DIV_W; i++) limit[i] = (i < int'(div_sel));
    tick = run && (div_q >= limit);
    if (!run || tick) div_d = '0;
    else              div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R3: with a divide above one, a tick is never followed at once by another
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> (!tick || div_sel == '0));
  // R9: stopping the generator restarts the divider
  assert_div_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0));
endmodule

// File: rtl/cg_set_latch.sv
module cg_set_latch
  import carrier_pkg::*;
#(
  parameter int unsigned CNT_W = CG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             set_sel,
  input  logic [CNT_W-1:0] pri_high,
  input  logic [CNT_W-1:0] pri_low,
  input  logic [CNT_W-1:0] alt_high,
  input  logic [CNT_W-1:0] alt_low,
  output logic [CNT_W-1:0] hi_len,
  output logic [CNT_W-1:0] lo_len,
  output logic             zero_err
);
  logic [CNT_W-1:0] pick_hi, pick_lo, hi_d, lo_d;
  logic             err_d;

  always_comb begin
    pick_hi = set_sel ? alt_high : pri_high;
    pick_lo = set_sel ? alt_low  : pri_low;
    hi_d    = hi_len;
    lo_d    = lo_len;
    err_d   = zero_err;
    if (load) begin
      hi_d  = (pick_hi == '0) ? CNT_W'(1) : pick_hi;
      lo_d  = (pick_lo == '0) ? CNT_W'(1) : pick_lo;
      err_d = zero_err || (pick_hi == '0) || (pick_lo == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len   <= CNT_W'(1);
      lo_len   <= CNT_W'(1);
      zero_err <= 1'b0;
    end else begin
      hi_len   <= hi_d;
      lo_len   <= lo_d;
      zero_err <= err_d;
    end
  end

  // R8: the error flag never clears without reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |=> zero_err);
  // R7: active lengths move only on a load
  assert_len_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hi_len) && $stable(lo_len)));
  // R8: active lengths are never zero
  assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len != '0) && (lo_len != '0));
endmodule

// File: rtl/cg_phase_ctr.sv
module cg_phase_ctr
  import carrier_pkg::*;
#(
  parameter int unsigned CNT_W = CG_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] hi_len,
  input  logic [CNT_W-1:0] lo_len,
  output phase_e           phase,
  output logic             boundary
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cur_len;
  phase_e           phase_d;
  logic             last;

  always_comb begin
    cur_len  = (phase == PH_HIGH) ? hi_len : lo_len;
    last     = (cnt_q == cur_len - CNT_W'(1));
    boundary = tick && last && (phase == PH_LOW);
    cnt_d    = cnt_q;
    phase_d  = phase;
    if (!run) begin
      cnt_d   = '0;
      phase_d = PH_HIGH;
    end else if (tick) begin
      if (last) begin
        cnt_d   = '0;
        phase_d = (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= PH_HIGH;
    end else begin
      cnt_q <= cnt_d;
      phase <= phase_d;
    end
  end

  // R2: the tick count stays inside the active phase length
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < cur_len));
  // R9: stopped generator restarts at the start of a high phase
  assert_restart_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == PH_HIGH && cnt_q == '0));
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
  import carrier_pkg::*;
#(
  parameter int unsigned CNT_W = CG_CNT_W,
  parameter int unsigned SEL_W = CG_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             hold_high,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] pri_high,
  input  logic [CNT_W-1:0] pri_low,
  input  logic [CNT_W-1:0] alt_high,
  input  logic [CNT_W-1:0] alt_low,
  input  logic             set_sel,
  output logic             carrier_out,
  output logic             period_end,
  output logic             zero_err
);
  logic             run, tick, boundary, load;
  logic [CNT_W-1:0] hi_len, lo_len;
  phase_e           phase;

  assign run  = enable && !hold_high;
  assign load = !run || boundary;

  cg_prescaler #(.SEL_W(SEL_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
  );

  cg_set_latch #(.CNT_W(CNT_W)) i_sets (
    .clk(clk), .rst_n(rst_n), .load(load), .set_sel(set_sel),
    .pri_high(pri_high), .pri_low(pri_low),
    .alt_high(alt_high), .alt_low(alt_low),
    .hi_len(hi_len), .lo_len(lo_len), .zero_err(zero_err)
  );

  cg_phase_ctr #(.CNT_W(CNT_W)) i_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .hi_len(hi_len), .lo_len(lo_len), .phase(phase), .boundary(boundary)
  );

  assign carrier_out = hold_high || (enable && phase == PH_HIGH);
  assign period_end  = boundary;

  // R4: the period strobe never lasts two cycles
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> !period_end);
  // R7: each new period opens with a high phase
  assert_new_period_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (carrier_out || !enable));
  // R10: no strobe while held high
  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_high |=> (!period_end || !hold_high));
endmodule

// File: tb/test_carrier_gen.sv
module test_carrier_gen;
  logic       clk = 1'b0;
  logic       rst_n, enable, hold_high, set_sel;
  logic [1:0] div_sel;
  logic [7:0] pri_high, pri_low, alt_high, alt_low;
  logic       carrier_out, period_end, zero_err;

  typedef struct {
    logic  car;
    logic  pe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   mon_en = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  carrier_gen i_carrier_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold_high(hold_high),
    .div_sel(div_sel), .pri_high(pri_high), .pri_low(pri_low),
    .alt_high(alt_high), .alt_low(alt_low), .set_sel(set_sel),
    .carrier_out(carrier_out), .period_end(period_end), .zero_err(zero_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: pops one expected item per cycle, mid-cycle
  always @(negedge clk) begin
    if (mon_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "queue-underrun", 0, 1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(carrier_out === e.car, {e.tag, " carrier_out"}, int'(carrier_out), int'(e.car));
        check(period_end === e.pe, {e.tag, " period_end"}, int'(period_end), int'(e.pe));
      end
    end
  end

  task automatic push(input logic car, input logic pe, input string tag);
    exp_t e;
    e.car = car; e.pe = pe; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic push_n(input int n, input logic car, input string tag);
    for (int i = 0; i < n; i++) push(car, 1'b0, tag);
  endtask

  // one full period: zero counts count as one tick
  task automatic push_period(input int s, input int h, input int l, input string tag);
    int hc, lc;
    hc = ((h == 0) ? 1 : h) * (1 << s);
    lc = ((l == 0) ? 1 : l) * (1 << s);
    for (int i = 0; i < hc; i++) push(1'b1, 1'b0, tag);
    for (int i = 0; i < lc; i++) push(1'b0, (i == lc - 1), tag);
  endtask

  task automatic go(input logic en, input logic hh);
    @(posedge clk); #1;
    enable = en; hold_high = hh; mon_en = 1'b1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
    enable = 1'b0; hold_high = 1'b0; mon_en = 1'b0;
  endtask

  task automatic at_cycle(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int s, input int ph, input int pl, input int ah, input int al, input logic ss);
    @(posedge clk); #1;
    div_sel = 2'(s); pri_high = 8'(ph); pri_low = 8'(pl);
    alt_high = 8'(ah); alt_low = 8'(al); set_sel = ss;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; hold_high = 1'b0; set_sel = 1'b0;
    div_sel = 2'd0; pri_high = 8'd3; pri_low = 8'd2; alt_high = 8'd4; alt_low = 8'd1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(carrier_out === 1'b0, "R1 carrier_out", int'(carrier_out), 0);
    check(period_end === 1'b0, "R1 period_end", int'(period_end), 0);
    check(zero_err === 1'b0, "R1 zero_err", int'(zero_err), 0);

    // R9: idle output
    push_n(4, 1'b0, "R9 idle");
    go(1'b0, 1'b0); drain();

    // R2 and R4: basic periods, divide 1
    cfg(0, 3, 2, 4, 1, 1'b0);
    push_period(0, 3, 2, "R2"); push_period(0, 3, 2, "R4");
    go(1'b1, 1'b0); drain();

    // R5: shortest period
    cfg(0, 1, 1, 4, 1, 1'b0);
    for (int p = 0; p < 3; p++) push_period(0, 1, 1, "R5");
    go(1'b1, 1'b0); drain();

    // R3: divide by 4 and by 8
    cfg(2, 2, 1, 4, 1, 1'b0);
    push_period(2, 2, 1, "R3 div4");
    go(1'b1, 1'b0); drain();
    cfg(3, 1, 2, 4, 1, 1'b0);
    push_period(3, 1, 2, "R3 div8");
    go(1'b1, 1'b0); drain();

    // R6: alternate pair chosen
    cfg(0, 1, 1, 4, 1, 1'b1);
    push_period(0, 4, 1, "R6 alt"); push_period(0, 4, 1, "R6 alt");
    go(1'b1, 1'b0); drain();

    // R7: set switch mid-period deferred to boundary
    cfg(0, 2, 2, 1, 3, 1'b0);
    push_period(0, 2, 2, "R7 fsk old");
    push_period(0, 1, 3, "R7 fsk new"); push_period(0, 1, 3, "R7 fsk new");
    go(1'b1, 1'b0);
    at_cycle(1); set_sel = 1'b1;
    drain();

    // R7: count change mid-period deferred
    cfg(0, 3, 1, 4, 1, 1'b0);
    push_period(0, 3, 1, "R7 cnt old"); push_period(0, 1, 2, "R7 cnt new");
    go(1'b1, 1'b0);
    at_cycle(1); pri_high = 8'd1; pri_low = 8'd2;
    drain();

    // R9: disable mid-period then fresh restart
    cfg(1, 2, 2, 4, 1, 1'b0);
    push(1'b1, 1'b0, "R9 part"); push(1'b1, 1'b0, "R9 part"); push(1'b1, 1'b0, "R9 part");
    go(1'b1, 1'b0); drain();
    push_n(3, 1'b0, "R9 off");
    go(1'b0, 1'b0); drain();
    push_period(1, 2, 2, "R9 restart");
    go(1'b1, 1'b0); drain();

    // R10: hold high with and without enable
    cfg(0, 1, 3, 4, 1, 1'b0);
    push_n(4, 1'b1, "R10 hold off");
    go(1'b0, 1'b1); drain();
    push_n(4, 1'b1, "R10 hold on");
    go(1'b1, 1'b1); drain();
    // R10: hold entered mid-period, cleared -> fresh high phase
    push(1'b1, 1'b0, "R10 run"); push(1'b0, 1'b0, "R10 run");
    push_n(3, 1'b1, "R10 held");
    push_period(0, 1, 3, "R10 fresh");
    go(1'b1, 1'b0);
    at_cycle(2); hold_high = 1'b1;
    at_cycle(3); hold_high = 1'b0;
    drain();

    // R8: zero count used as one tick, sticky flag
    @(negedge clk);
    check(zero_err === 1'b0, "R8 flag before zero", int'(zero_err), 0);
    cfg(0, 0, 2, 4, 1, 1'b0);
    push_period(0, 0, 2, "R8 zero"); push_period(0, 0, 2, "R8 zero");
    go(1'b1, 1'b0); drain();
    @(negedge clk);
    check(zero_err === 1'b1, "R8 flag set", int'(zero_err), 1);
    cfg(0, 2, 2, 4, 1, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(zero_err === 1'b1, "R8 flag sticky", int'(zero_err), 1);
    do_reset();
    @(negedge clk);
    check(zero_err === 1'b0, "R1 flag cleared by reset", int'(zero_err), 0);
    check(carrier_out === 1'b0, "R1 carrier after reset", int'(carrier_out), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule